// File: doc/BRIEF.md
# User-Defined Glyph Store

This block holds a small set of custom 5x7 dot-matrix glyphs inside a display controller. A host writes glyphs over a simple strobe bus. The first write loads a 4-bit slot pointer into an indirect address register. The next seven writes each land in one row of the glyph that the pointer selects. Loading a complete glyph therefore takes eight bus cycles. The host can read back both the pointer and any row of the current glyph.

A second read port is separate from the host bus and serves the display refresh logic. It returns, with no clock delay, the five dots of any row of any slot. Within a row, bit 0 is the rightmost column and bit 4 is the leftmost. The refresh logic shifts the row out in that order.

Top module: `glyph_store`

## Requirements
- R1: A write with flash_sel=0 and addr[4:3]=00 stores wdata[3:0] as the slot pointer. wdata[7:4] is ignored.
- R2: A read with flash_sel=0 and addr[4:3]=00 returns {4'b0000, pointer}.
- R3: A write with flash_sel=0 and addr[4:3]=01 stores wdata[4:0] into row addr[2:0] of the slot the pointer selects. Row 000 is the top row and row 110 is the bottom row. wdata[7:5] is ignored.
- R4: Inside a stored row, and on the host and refresh read paths, bit 0 is the rightmost column and bit 4 is the leftmost column.
- R5: A read with flash_sel=0 and addr[4:3]=01 returns {3'b000, row addr[2:0] of the pointed slot}.
- R6: A row write to addr[2:0]=111 changes no stored row. A read of row 111 returns zero on both read ports.
- R7: A write takes effect on a rising clock edge only while cs_n=0, wr_n=0 and rd_n=1. When both strobes are low, or when cs_n is high, nothing is stored.
- R8: An access with flash_sel=1, or with addr[4]=1, stores nothing and reads back zero.
- R9: A synchronous active-high reset clears the pointer to 0 and leaves the glyph contents unchanged.
- R10: The refresh port returns row scan_row of slot scan_slot combinationally, whatever the host bus is doing.
- R11: rdata is zero whenever no read is in progress (a read needs cs_n=0, rd_n=0, wr_n=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip enable, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| flash_sel | input | 1 | Selects the attribute space when high (outside this block) |
| addr | input | 5 | Bits 4:3 choose the space; bits 2:0 choose the row |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data |
| scan_slot | input | 4 | Refresh port slot index |
| scan_row | input | 3 | Refresh port row index |
| scan_dots | output | 5 | Refresh port row dots |

## Verification
The assertions check on every cycle that:
- a pointer write loads the low nibble of wdata and that the pointer holds its value otherwise;
- a row write lands in the addressed cell;
- row 111 is never written;
- rdata has zero upper bits and is zero when no read is active.

Some behaviours only the bench scenarios can show:
- the column bit order, using a known glyph;
- that the invalid strobe combinations leave the pointer untouched;
- that accesses to other address spaces leave the pointer untouched;
- that reset keeps the glyph contents;
- that one slot can be written without disturbing another.

// File: rtl/glyph_store_pkg.sv
package glyph_store_pkg;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_PTR  = 2'd1,
        TGT_ROW  = 2'd2
    } target_e;

    typedef struct packed {
        logic    wr;
        logic    rd;
        target_e tgt;
    } bus_op_t;

    function automatic target_e space_of(input logic fl, input logic [1:0] sp);
        if (fl)
            return TGT_NONE;
        case (sp)
            2'b00:   return TGT_PTR;
            2'b01:   return TGT_ROW;
            default: return TGT_NONE;
        endcase
    endfunction

endpackage

// File: rtl/glyph_bus_decode.sv
module glyph_bus_decode
    import glyph_store_pkg::*;
#(
    parameter int ROW_W = 3
) (
    input  logic               cs_n,
    input  logic               wr_n,
    input  logic               rd_n,
    input  logic               flash_sel,
    input  logic [ROW_W+1:0]   addr,
    output bus_op_t            op,
    output logic [ROW_W-1:0]   row_idx
);
    logic sel;

    always_comb begin
        sel     = !cs_n;
        op.wr   = sel && !wr_n && rd_n;
        op.rd   = sel && !rd_n && wr_n;
        op.tgt  = space_of(flash_sel, addr[ROW_W+1:ROW_W]);
        row_idx = addr[ROW_W-1:0];
    end

    always_comb begin
        assert (!(op.wr && op.rd)) else $error("AST_STROBE_EXCL"); // R7
    end
endmodule

// File: rtl/glyph_row_mem.sv
module glyph_row_mem #(
    parameter int SLOT_W = 4,
    parameter int ROW_W  = 3,
    parameter int COLS   = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [SLOT_W-1:0] w_slot,
    input  logic [ROW_W-1:0]  w_row,
    input  logic [COLS-1:0]   w_dots,
    input  logic [SLOT_W-1:0] r_slot [2],
    input  logic [ROW_W-1:0]  r_row  [2],
    output logic [COLS-1:0]   r_dots [2]
);
    localparam int N_SLOTS = 1 << SLOT_W;
    localparam int N_ROWS  = (1 << ROW_W) - 1;

    logic [COLS-1:0] cells [N_SLOTS][N_ROWS];
    logic            w_ok;

    assign w_ok = we && (int'(w_row) < N_ROWS);

    always_ff @(posedge clk) begin
        if (w_ok)
            cells[w_slot][w_row] <= w_dots;
    end

    for (genvar p = 0; p < 2; p++) begin : g_rd
        always_comb begin
            if (int'(r_row[p]) < N_ROWS)
                r_dots[p] = cells[r_slot[p]][r_row[p]];
            else
                r_dots[p] = '0;
        end
    end

    AST_ROW_STORE: assert property (@(posedge clk) disable iff (rst)
        w_ok |=> cells[$past(w_slot)][$past(w_row)] == $past(w_dots)); // R3
    AST_ROW7_ZERO: assert property (@(posedge clk) disable iff (rst)
        (int'(r_row[1]) == N_ROWS) |-> (r_dots[1] == '0)); // R6
endmodule

// File: rtl/glyph_store.sv
module glyph_store
    import glyph_store_pkg::*;
#(
    parameter int SLOT_W = 4,
    parameter int ROW_W  = 3,
    parameter int COLS   = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              flash_sel,
    input  logic [ROW_W+1:0]  addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [SLOT_W-1:0] scan_slot,
    input  logic [ROW_W-1:0]  scan_row,
    output logic [COLS-1:0]   scan_dots
);
    bus_op_t           op;
    logic [ROW_W-1:0]  row_idx;
    logic [SLOT_W-1:0] ptr;
    logic              ptr_we;
    logic              row_we;
    logic [SLOT_W-1:0] rd_slot [2];
    logic [ROW_W-1:0]  rd_row  [2];
    logic [COLS-1:0]   rd_dots [2];

    glyph_bus_decode #(.ROW_W(ROW_W)) u_dec (
        .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n), .flash_sel(flash_sel),
        .addr(addr), .op(op), .row_idx(row_idx)
    );

    assign ptr_we = op.wr && (op.tgt == TGT_PTR);
    assign row_we = op.wr && (op.tgt == TGT_ROW);

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (ptr_we)
            ptr <= wdata[SLOT_W-1:0];
    end

    assign rd_slot[0] = ptr;
    assign rd_row[0]  = row_idx;
    assign rd_slot[1] = scan_slot;
    assign rd_row[1]  = scan_row;

    glyph_row_mem #(.SLOT_W(SLOT_W), .ROW_W(ROW_W), .COLS(COLS)) u_mem (
        .clk(clk), .rst(rst), .we(row_we), .w_slot(ptr), .w_row(row_idx),
        .w_dots(wdata[COLS-1:0]), .r_slot(rd_slot), .r_row(rd_row), .r_dots(rd_dots)
    );

    assign scan_dots = rd_dots[1];

    always_comb begin
        rdata = '0;
        if (op.rd) begin
            case (op.tgt)
                TGT_PTR: rdata[SLOT_W-1:0] = ptr;
                TGT_ROW: rdata[COLS-1:0]   = rd_dots[0];
                default: rdata = '0;
            endcase
        end
    end

    AST_PTR_LOAD: assert property (@(posedge clk) disable iff (rst)
        ptr_we |=> ptr == $past(wdata[SLOT_W-1:0])); // R1
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ptr_we |=> $stable(ptr)); // R7
    AST_PTR_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ptr == '0); // R9
    AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        rdata[DATA_W-1:COLS] == '0); // R5
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !(!cs_n && !rd_n && wr_n) |-> rdata == '0); // R11
endmodule

// File: tb/glyph_store_test.sv
module glyph_store_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, flash_sel = 1'b0;
    logic [4:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [3:0] scan_slot = '0;
    logic [2:0] scan_row = '0;
    logic [4:0] scan_dots;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        string      req;
        logic [7:0] exp;
        bit         is_scan;
    } item_t;

    item_t sb[$];
    event  sample_ev;

    always #10 clk = ~clk;

    glyph_store uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .flash_sel(flash_sel), .addr(addr), .wdata(wdata), .rdata(rdata),
        .scan_slot(scan_slot), .scan_row(scan_row), .scan_dots(scan_dots)
    );

    initial begin : monitor
        forever begin
            @(sample_ev);
            while (sb.size() > 0) begin
                item_t it;
                logic [7:0] got;
                it = sb.pop_front();
                got = it.is_scan ? {3'b000, scan_dots} : rdata;
                checks++;
                if (got !== it.exp) begin
                    failures++;
                    $display("FAIL %s actual=%02h expected=%02h", it.req, got, it.exp);
                end
            end
        end
    end

    task automatic bus_write(input logic fl, input logic [4:0] a, input logic [7:0] d,
                             input logic c = 1'b0, input logic r = 1'b1);
        @(negedge clk);
        flash_sel = fl; addr = a; wdata = d; cs_n = c; wr_n = 1'b0; rd_n = r;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic bus_read(input string req, input logic fl, input logic [4:0] a,
                            input logic [7:0] exp);
        @(negedge clk);
        flash_sel = fl; addr = a; cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b1;
        #1;
        sb.push_back('{req, exp, 1'b0});
        -> sample_ev;
        #2;
        cs_n = 1'b1; rd_n = 1'b1; flash_sel = 1'b0;
    endtask

    task automatic scan_check(input string req, input logic [3:0] s, input logic [2:0] r,
                              input logic [4:0] exp);
        scan_slot = s; scan_row = r;
        #1;
        sb.push_back('{req, {3'b000, exp}, 1'b1});
        -> sample_ev;
        #1;
    endtask

    task automatic idle_check(input string req);
        @(negedge clk);
        #1;
        sb.push_back('{req, 8'h00, 1'b0});
        -> sample_ev;
    endtask

    // Glyph "F": leftmost column in bit 4, rightmost in bit 0
    logic [4:0] glyph_f [7] = '{5'h1F, 5'h10, 5'h10, 5'h1E, 5'h10, 5'h10, 5'h10};
    logic [4:0] glyph_b [7] = '{5'h0E, 5'h11, 5'h11, 5'h1F, 5'h11, 5'h11, 5'h11};

    initial begin : driver
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        bus_read("R9 reset pointer", 1'b0, 5'b00000, 8'h00);
        idle_check("R11 idle rdata");

        bus_write(1'b0, 5'b00000, 8'hA5);                      // R1
        bus_read("R1/R2 pointer load upper ignored", 1'b0, 5'b00000, 8'h05);

        for (int r = 0; r < 7; r++)                            // R3
            bus_write(1'b0, {2'b01, 3'(r)}, {3'b111, glyph_f[r]});
        for (int r = 0; r < 7; r++)
            bus_read("R3/R5 row readback", 1'b0, {2'b01, 3'(r)}, {3'b000, glyph_f[r]});
        scan_check("R4 top row all columns", 4'd5, 3'd0, 5'h1F);
        scan_check("R4 row4 rightmost dark leftmost lit", 4'd5, 3'd3, 5'h1E);

        bus_write(1'b0, 5'b01111, 8'h1F);                      // R6
        bus_read("R6 row 111 reads zero", 1'b0, 5'b01111, 8'h00);
        scan_check("R6 scan row 111 zero", 4'd5, 3'd7, 5'h00);
        bus_read("R6 bottom row intact", 1'b0, 5'b01110, 8'h10);

        bus_write(1'b0, 5'b00000, 8'h03, 1'b0, 1'b0);          // R7 both strobes
        bus_read("R7 both strobes no write", 1'b0, 5'b00000, 8'h05);
        bus_write(1'b0, 5'b00000, 8'h03, 1'b1, 1'b1);          // R7 cs_n high
        bus_read("R7 chip disabled no write", 1'b0, 5'b00000, 8'h05);

        bus_write(1'b1, 5'b00000, 8'h0C);                      // R8
        bus_read("R8 flash_sel write ignored", 1'b0, 5'b00000, 8'h05);
        bus_write(1'b0, 5'b10000, 8'h0C);
        bus_read("R8 addr4 write ignored", 1'b0, 5'b00000, 8'h05);
        bus_read("R8 flash_sel read zero", 1'b1, 5'b00000, 8'h00);
        bus_read("R8 addr4 read zero", 1'b0, 5'b11000, 8'h00);

        bus_write(1'b0, 5'b00000, 8'h00);
        for (int r = 0; r < 7; r++)
            bus_write(1'b0, {2'b01, 3'(r)}, {3'b000, glyph_b[r]});
        scan_check("R10 slot0 via scan", 4'd0, 3'd3, 5'h1F);
        scan_check("R10 slot5 untouched", 4'd5, 3'd1, 5'h10);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b1; rd_n = 1'b0; addr = 5'b01000;
        scan_check("R10 scan during host read", 4'd5, 3'd0, 5'h1F);
        cs_n = 1'b1; rd_n = 1'b1;

        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        bus_read("R9 pointer cleared", 1'b0, 5'b00000, 8'h00);
        scan_check("R9 glyph kept", 4'd5, 3'd0, 5'h1F);
        bus_read("R9 slot0 row kept", 1'b0, 5'b01001, 8'h11);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule